// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital controller of a 12-bit successive-approximation converter. All of its timing is counted in conversion clock periods, which reach it as a one-cycle tick enable (`tad_tick`). Software enables the converter and, once a settling delay has passed, sets a start bit (`ctrl_go`). The sequencer keeps the sample-hold connected for a programmable number of periods, which may be zero. It then disconnects the hold and resolves the code from the most significant bit down. For each trial it drives a code to the DAC and reads a single comparator decision back.

When the last bit is known, the sequencer loads the result register, drops the busy/start bit and raises a sticky completion flag, all on one clock. Clearing the start bit early abandons the work and leaves the previous result in place. Every completion or abandonment is followed by a fixed recovery wait. During that wait the holding array is discharged. After it, sampling resumes on its own, and a start request that arrived during the wait then takes effect.

Top module: `sar_seq_top`

## Requirements
- R1: After reset the start bit, completion flag, result, DAC code, sample strobe and discharge strobe are all zero, and the converter is disabled.
- R2: A start request written in the same write that enables the converter, or written during the SETTLE_TADS ticks that follow the enable, is dropped. Once those ticks have passed, the sample strobe is high.
- R3: The 3-bit acquisition code selects 0, 2, 4, 6, 8, 12, 16 or 20 ticks for codes 0 to 7. With a non-zero time, the sample strobe stays high for exactly that many ticks after the cycle in which the start bit reads back set, then falls.
- R4: With acquisition code 0, the sample strobe falls on the clock after the start bit is set, without waiting for any tick.
- R5: The first tick of a conversion decides nothing and puts 0x800 on the DAC code. Each later tick keeps the bit under test when `cmp_in` is 1 (input at or above the DAC code) and clears it otherwise, then sets the next lower bit. The result equals the input level for every 12-bit level. The DAC code is zero outside a conversion.
- R6: One clock after the thirteenth conversion tick, the result is loaded, the start bit reads 0 and the completion flag reads 1, together.
- R7: Clearing the start bit during acquisition or conversion ends the work. The result is not changed and the flag is not set.
- R8: After a completion or an abort, the discharge strobe is high and the sample strobe low for exactly 2 ticks. After that the sample strobe is high and the discharge strobe low. The two strobes are never high together.
- R9: A start request written during the recovery wait is held, and the conversion starts as soon as the wait ends.
- R10: A result write takes effect when no acquisition or conversion is in progress and is ignored otherwise.
- R11: The completion flag stays set until `flag_clr` is pulsed.
- R12: A control write with the enable bit at 0 stops any work at once. Both strobes and the DAC code go to zero and the result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_en | input | 1 | Converter enable field of the control write |
| ctrl_go | input | 1 | Start/busy field of the control write |
| ctrl_acq | input | 3 | Acquisition time code of the control write |
| res_wr | input | 1 | Result register write strobe |
| res_wdata | input | RES_BITS | Result register write data |
| flag_clr | input | 1 | Clears the completion flag |
| tad_tick | input | 1 | One pulse per conversion clock period |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC code |
| go_busy | output | 1 | Start bit read-back, high while a request is pending or running |
| done_flag | output | 1 | Sticky completion flag |
| result | output | RES_BITS | Result register |
| dac_code | output | RES_BITS | Trial code for the DAC |
| sample_on | output | 1 | Connect sample-hold to the input |
| discharge_on | output | 1 | Discharge the holding array |

## Verification
Several properties are checked on every cycle:
- the two strobes are mutually exclusive;
- the flag is sticky;
- the result changes only through a software write or a completion;
- a rising flag always coincides with the start bit falling;
- the start bit rises only through an enabling control write;
- no trial code appears while sampling or discharging;
- a discharge period lasts more than one cycle.

The tick-exact lengths need the bench's scenarios, driven by single ticks. These are the acquisition length for all eight codes, the zero-time start, the two-tick recovery and the settling window. The same holds for the pending start during recovery, the dropped result write during acquisition and the disable path. An exhaustive sweep over all 4096 input levels shows that the bit decisions are correct.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_IDLE,
    ST_ACQ,
    ST_CONV,
    ST_DONE,
    ST_REC
  } seq_state_t;

  localparam int ACQ_CODE_W = 3;

  // Acquisition code to tick count: steps of 2 up to 8, then steps of 4.
  function automatic int acq_tads(input logic [ACQ_CODE_W-1:0] code);
    if (code < 3'd4) return 2 * int'(code);
    else return 4 * (int'(code) - 2);
  endfunction

endpackage

// File: rtl/sar_seq_tadcnt.sv
module sar_seq_tadcnt #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
  end

  // Last tick of the loaded window.
  assign expire = tick && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sar_seq_sar.sv
module sar_seq_sar #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         start,
  input  logic         step,
  input  logic         cmp_in,
  output logic [N-1:0] code,
  output logic         armed,
  output logic         on_lsb
);

  localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] code_q;
  logic [N-1:0] sel_q;   // one-hot pointer to the bit under test

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code_q <= '0;
      sel_q  <= '0;
    end else if (start) begin
      code_q <= MSB_ONLY;
      sel_q  <= MSB_ONLY;
    end else if (step) begin
      code_q <= (cmp_in ? code_q : (code_q & ~sel_q)) | (sel_q >> 1);
      sel_q  <= sel_q >> 1;
    end
  end

  assign code   = code_q;
  assign armed  = |sel_q;
  assign on_lsb = sel_q[0];

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_seq_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int SETTLE_TADS = 3,
  parameter int REC_TADS    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  go,
  input  logic [ACQ_CODE_W-1:0] acq_code,
  input  logic                  tick,
  input  logic                  cnt_expire,
  input  logic                  sar_armed,
  input  logic                  sar_on_lsb,
  output seq_state_t            state,
  output logic                  cnt_load,
  output logic [CNT_W-1:0]      cnt_val,
  output logic                  sar_start,
  output logic                  sar_step,
  output logic                  sar_clear
);

  seq_state_t st_d;

  always_comb begin
    st_d      = state;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    sar_start = 1'b0;
    sar_step  = 1'b0;
    sar_clear = 1'b0;
    if (!en) begin
      st_d      = ST_OFF;
      sar_clear = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: begin
          st_d     = ST_SETTLE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(SETTLE_TADS);
        end
        ST_SETTLE: if (cnt_expire) st_d = ST_IDLE;
        ST_IDLE: begin
          if (go) begin
            if (acq_tads(acq_code) == 0) begin
              st_d = ST_CONV;
            end else begin
              st_d     = ST_ACQ;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(acq_tads(acq_code));
            end
          end
        end
        ST_ACQ: begin
          if (!go) begin
            st_d     = ST_REC;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(REC_TADS);
          end else if (cnt_expire) begin
            st_d = ST_CONV;
          end
        end
        ST_CONV: begin
          if (!go) begin
            st_d      = ST_REC;
            cnt_load  = 1'b1;
            cnt_val   = CNT_W'(REC_TADS);
            sar_clear = 1'b1;
          end else if (tick) begin
            if (!sar_armed) begin
              sar_start = 1'b1;
            end else begin
              sar_step = 1'b1;
              if (sar_on_lsb) st_d = ST_DONE;
            end
          end
        end
        ST_DONE: begin
          st_d      = ST_REC;
          cnt_load  = 1'b1;
          cnt_val   = CNT_W'(REC_TADS);
          sar_clear = 1'b1;
        end
        ST_REC: if (cnt_expire) st_d = ST_IDLE;
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else state <= st_d;
  end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SETTLE_TADS = 3,
  parameter int REC_TADS    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ctrl_wr,
  input  logic                  ctrl_en,
  input  logic                  ctrl_go,
  input  logic [ACQ_CODE_W-1:0] ctrl_acq,
  input  logic                  res_wr,
  input  logic [RES_BITS-1:0]   res_wdata,
  input  logic                  flag_clr,
  input  logic                  tad_tick,
  input  logic                  cmp_in,
  output logic                  go_busy,
  output logic                  done_flag,
  output logic [RES_BITS-1:0]   result,
  output logic [RES_BITS-1:0]   dac_code,
  output logic                  sample_on,
  output logic                  discharge_on
);

  localparam int ACQ_MAX  = acq_tads({ACQ_CODE_W{1'b1}});
  localparam int WAIT_A   = (SETTLE_TADS > ACQ_MAX) ? SETTLE_TADS : ACQ_MAX;
  localparam int WAIT_MAX = (REC_TADS > WAIT_A) ? REC_TADS : WAIT_A;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  logic                  en_q;
  logic                  go_q;
  logic                  flag_q;
  logic [ACQ_CODE_W-1:0] acq_q;
  logic [RES_BITS-1:0]   result_q;

  seq_state_t            st;
  logic                  cnt_load;
  logic [CNT_W-1:0]      cnt_val;
  logic                  cnt_expire;
  logic                  sar_start;
  logic                  sar_step;
  logic                  sar_clear;
  logic [RES_BITS-1:0]   sar_code;
  logic                  sar_armed;
  logic                  sar_on_lsb;
  logic                  conv_busy;
  logic                  go_ok;
  logic                  finishing;

  assign conv_busy = (st == ST_ACQ) || (st == ST_CONV) || (st == ST_DONE);
  assign go_ok     = en_q && (st != ST_OFF) && (st != ST_SETTLE);
  assign finishing = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      go_q     <= 1'b0;
      flag_q   <= 1'b0;
      acq_q    <= '0;
      result_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= ctrl_en;
        acq_q <= ctrl_acq;
      end
      if (finishing) go_q <= 1'b0;
      else if (ctrl_wr) go_q <= ctrl_en && ctrl_go && go_ok;
      if (finishing) result_q <= sar_code;
      else if (res_wr && !conv_busy) result_q <= res_wdata;
      if (finishing) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  sar_seq_fsm #(
    .CNT_W      (CNT_W),
    .SETTLE_TADS(SETTLE_TADS),
    .REC_TADS   (REC_TADS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .go        (go_q),
    .acq_code  (acq_q),
    .tick      (tad_tick),
    .cnt_expire(cnt_expire),
    .sar_armed (sar_armed),
    .sar_on_lsb(sar_on_lsb),
    .state     (st),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .sar_start (sar_start),
    .sar_step  (sar_step),
    .sar_clear (sar_clear)
  );

  sar_seq_tadcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_val),
    .tick    (tad_tick),
    .expire  (cnt_expire)
  );

  sar_seq_sar #(.N(RES_BITS)) u_sar (
    .clk   (clk),
    .rst   (rst),
    .clear (sar_clear),
    .start (sar_start),
    .step  (sar_step),
    .cmp_in(cmp_in),
    .code  (sar_code),
    .armed (sar_armed),
    .on_lsb(sar_on_lsb)
  );

  assign go_busy      = go_q;
  assign done_flag    = flag_q;
  assign result       = result_q;
  assign dac_code     = (st == ST_CONV) ? sar_code : '0;
  assign sample_on    = (st == ST_IDLE) || (st == ST_ACQ);
  assign discharge_on = (st == ST_REC);

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_BITS = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                ctrl_wr,
  input logic                ctrl_en,
  input logic                res_wr,
  input logic                flag_clr,
  input logic                go_busy,
  input logic                done_flag,
  input logic [RES_BITS-1:0] result,
  input logic [RES_BITS-1:0] dac_code,
  input logic                sample_on,
  input logic                discharge_on
);

  // R8: strobes exclusive
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(sample_on && discharge_on));

  // R11: sticky flag
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !flag_clr) |=> done_flag);

  // R7: result only moves on a software write or a completion
  assert_result_source_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> ($past(res_wr) || $fell(go_busy)));

  // R6: flag rises together with the start bit falling
  assert_done_together_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $fell(go_busy));

  // R2: start bit only set by an enabling control write
  assert_go_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(go_busy) |-> ($past(ctrl_wr) && $past(ctrl_en)));

  // R5: no trial code while sampling or discharging
  assert_dac_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (dac_code != '0) |-> (!sample_on && !discharge_on));

  // R8: discharge lasts longer than one cycle unless disabled
  assert_rec_len_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(discharge_on) && !$past(ctrl_wr && !ctrl_en)) |=> discharge_on);

endmodule

bind sar_seq_top sar_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctrl_wr     (ctrl_wr),
  .ctrl_en     (ctrl_en),
  .res_wr      (res_wr),
  .flag_clr    (flag_clr),
  .go_busy     (go_busy),
  .done_flag   (done_flag),
  .result      (result),
  .dac_code    (dac_code),
  .sample_on   (sample_on),
  .discharge_on(discharge_on)
);

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;

  localparam int RB = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctrl_wr = 1'b0, ctrl_en = 1'b0, ctrl_go = 1'b0;
  logic [2:0]    ctrl_acq = 3'd0;
  logic          res_wr = 1'b0;
  logic [RB-1:0] res_wdata = '0;
  logic          flag_clr = 1'b0;
  logic          tick_man = 1'b0, tick_auto = 1'b0;
  logic          tad_tick;
  logic          cmp_in;
  logic [RB-1:0] vin = '0;
  logic          go_busy, done_flag, sample_on, discharge_on;
  logic [RB-1:0] result, dac_code;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign tad_tick = tick_man | tick_auto;
  assign cmp_in   = (vin >= dac_code);

  sar_seq_top #(.RES_BITS(RB), .SETTLE_TADS(3), .REC_TADS(2)) dut (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_go(ctrl_go),
    .ctrl_acq(ctrl_acq), .res_wr(res_wr), .res_wdata(res_wdata), .flag_clr(flag_clr),
    .tad_tick(tad_tick), .cmp_in(cmp_in), .go_busy(go_busy), .done_flag(done_flag),
    .result(result), .dac_code(dac_code), .sample_on(sample_on), .discharge_on(discharge_on)
  );

  function automatic int exp_acq(input int c);
    return (c < 4) ? 2 * c : 4 * (c - 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic ctrl_write(input logic en, input logic go, input logic [2:0] acq);
    @(negedge clk);
    ctrl_wr = 1'b1; ctrl_en = en; ctrl_go = go; ctrl_acq = acq;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic res_write(input logic [RB-1:0] d);
    @(negedge clk);
    res_wr = 1'b1; res_wdata = d;
    @(negedge clk);
    res_wr = 1'b0;
  endtask

  task automatic clr_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_man = 1'b1;
    @(negedge clk);
    tick_man = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int k = 0;
    while (!done_flag && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(req, int'(done_flag), 1);
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (!sample_on && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(req, int'(sample_on), 1);
  endtask

  task automatic run_conv(input logic [RB-1:0] v);
    vin = v;
    ctrl_write(1'b1, 1'b1, 3'd0);
    wait_flag("R6 flag after sweep conversion");
    chk("R5 sweep result", int'(result), int'(v));
    chk("R6 start bit cleared", int'(go_busy), 0);
    clr_flag();
    wait_idle("R8 sampling resumes");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    chk("R1 go", int'(go_busy), 0);
    chk("R1 flag", int'(done_flag), 0);
    chk("R1 result", int'(result), 0);
    chk("R1 dac", int'(dac_code), 0);
    chk("R1 sample", int'(sample_on), 0);
    chk("R1 discharge", int'(discharge_on), 0);

    // R2: start with the enable and during settling is dropped
    ctrl_write(1'b1, 1'b1, 3'd0);
    chk("R2 go with enable dropped", int'(go_busy), 0);
    ctrl_write(1'b1, 1'b1, 3'd0);
    chk("R2 go during settle dropped", int'(go_busy), 0);
    tick1(); tick1();
    chk("R2 not yet settled", int'(sample_on), 0);
    tick1();
    chk("R2 settled sampling", int'(sample_on), 1);

    // R4 / R5 / R6 / R8: zero acquisition, single-tick conversion
    vin = 12'hA5C;
    ctrl_write(1'b1, 1'b1, 3'd0);
    chk("R4 go set", int'(go_busy), 1);
    chk("R4 still sampling", int'(sample_on), 1);
    @(negedge clk);
    chk("R4 hold disconnected next clock", int'(sample_on), 0);
    tick1();
    chk("R5 msb trial", int'(dac_code), 'h800);
    tick1();
    chk("R5 b11 kept and b10 trial", int'(dac_code), 'hC00);
    for (int i = 0; i < 10; i++) tick1();
    chk("R6 flag not yet", int'(done_flag), 0);
    tick1();
    chk("R6 flag not on last tick", int'(done_flag), 0);
    chk("R6 go still set", int'(go_busy), 1);
    @(negedge clk);
    chk("R6 flag set", int'(done_flag), 1);
    chk("R6 go cleared", int'(go_busy), 0);
    chk("R6 result loaded", int'(result), 'hA5C);
    chk("R8 discharge on", int'(discharge_on), 1);
    chk("R8 sample off", int'(sample_on), 0);
    repeat (3) @(negedge clk);
    chk("R11 flag sticky", int'(done_flag), 1);
    clr_flag();
    chk("R11 flag cleared", int'(done_flag), 0);

    // R9: pending start during recovery
    vin = 12'h3C1;
    ctrl_write(1'b1, 1'b1, 3'd0);
    chk("R9 go held", int'(go_busy), 1);
    chk("R9 still recovering", int'(sample_on), 0);
    tick1();
    chk("R8 discharge after 1 tick", int'(discharge_on), 1);
    tick1();
    chk("R8 discharge done after 2 ticks", int'(discharge_on), 0);
    chk("R8 sampling after recovery", int'(sample_on), 1);
    @(negedge clk);
    chk("R9 pending conversion started", int'(sample_on), 0);
    tick_auto = 1'b1;
    wait_flag("R9 pending conversion completes");
    chk("R9 pending result", int'(result), 'h3C1);
    clr_flag();
    wait_idle("R8 idle after pending");
    tick_auto = 1'b0;

    // R3 / R7: every acquisition code, then abort during conversion
    for (int c = 0; c < 8; c++) begin
      int n;
      n = exp_acq(c);
      ctrl_write(1'b1, 1'b1, 3'(c));
      if (n == 0) begin
        @(negedge clk);
        chk("R3 code 0 no acquisition", int'(sample_on), 0);
      end else begin
        for (int k = 0; k < n - 1; k++) tick1();
        chk("R3 acquiring before last tick", int'(sample_on), 1);
        tick1();
        chk("R3 acquisition ended", int'(sample_on), 0);
      end
      tick1();
      ctrl_write(1'b1, 1'b0, 3'(c));
      @(negedge clk);
      chk("R7 abort result kept", int'(result), 'h3C1);
      chk("R7 abort no flag", int'(done_flag), 0);
      chk("R8 discharge after abort", int'(discharge_on), 1);
      tick1(); tick1();
      chk("R8 sampling after abort", int'(sample_on), 1);
    end

    // R10 / R7: result write, ignored during acquisition, abort in acquisition
    res_write(12'hABC);
    chk("R10 idle write", int'(result), 'hABC);
    ctrl_write(1'b1, 1'b1, 3'd2);
    tick1();
    res_write(12'h123);
    chk("R10 write ignored in acquisition", int'(result), 'hABC);
    ctrl_write(1'b1, 1'b0, 3'd2);
    @(negedge clk);
    chk("R7 abort in acquisition", int'(discharge_on), 1);
    chk("R7 result kept", int'(result), 'hABC);
    tick1(); tick1();
    chk("R8 back to sampling", int'(sample_on), 1);

    // R5: exhaustive sweep of input levels
    tick_auto = 1'b1;
    for (int v = 0; v < (1 << RB); v++) run_conv(RB'(v));
    tick_auto = 1'b0;

    // R12: disable mid-conversion
    vin = 12'h555;
    ctrl_write(1'b1, 1'b1, 3'd0);
    tick1(); tick1(); tick1();
    ctrl_write(1'b0, 1'b0, 3'd0);
    chk("R12 go dropped", int'(go_busy), 0);
    @(negedge clk);
    chk("R12 sample off", int'(sample_on), 0);
    chk("R12 discharge off", int'(discharge_on), 0);
    chk("R12 dac zero", int'(dac_code), 0);
    tick1(); tick1();
    chk("R12 result kept", int'(result), 'hFFF);
    chk("R12 no flag", int'(done_flag), 0);

    summary();
  end

endmodule